// File: doc/BRIEF.md
# Chainable Pair of Byte Counters

This block holds two byte-wide up-counters, a low one and a high one. Both advance on a shared count tick. They can run as two independent counters, or they can be chained into one double-width counter with the high counter as the most significant byte. A single mode pin selects the configuration. Each counter has its own run pin and its own load port. A loaded byte replaces the count on the next clock edge.

In chained mode the low run pin starts and stops the whole pair. The high byte takes a carry only when its own run pin is also set. If the high run pin is clear, the upper byte stays frozen while the lower byte keeps wrapping. Each counter reports a wrap with a one-cycle pulse. In chained mode the high pulse fires only when the full value wraps from all ones to zero.

Every pin is a plain control or status signal. There is no stream interface, so no back-pressure applies. A load is accepted in any cycle.

Top module: `cascade_timer`

## Requirements
- R1: On reset both counts are 0x00 and both wrap pulses are 0.
- R2: With the mode pin at 0, the low counter advances by one on each cycle in which the tick and the low run pin are 1, and the high counter advances on each cycle in which the tick and the high run pin are 1. Neither run pin affects the other counter.
- R3: A counter whose increment conditions are not met holds its value. This includes a cycle with the tick at 0.
- R4: With the mode pin at 1, the high counter advances only in a cycle where the low counter goes from 0xFF to 0x00 through a tick, with both run pins at 1.
- R5: With the mode pin at 1 and the high run pin at 0, the high byte stays frozen while the low byte keeps counting and wrapping.
- R6: With the mode pin at 1 and the low run pin at 0, neither byte advances, whatever the high run pin is.
- R7: A load into a counter takes priority over an increment in the same cycle. The loaded value appears on the next cycle. A load into the low byte in chained mode produces no carry into the high byte.
- R8: The low wrap pulse is 1 for exactly the one cycle in which the low count first shows 0x00 after an increment from 0xFF.
- R9: With the mode pin at 0, the high wrap pulse is 1 for the one cycle after the high counter increments from 0xFF to 0x00.
- R10: With the mode pin at 1, the high wrap pulse is 1 only in the cycle after the combined value goes from 0xFFFF to 0x0000. A low-byte wrap with any other upper byte leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable tick |
| join16 | input | 1 | 1 = chained double-width mode, 0 = two independent counters |
| run_lo | input | 1 | Low counter run; in chained mode it runs the pair |
| run_hi | input | 1 | High counter run; in chained mode it gates the carry into the upper byte |
| wr_lo_en | input | 1 | Load strobe for the low counter |
| wr_lo_data | input | 8 | Load value for the low counter |
| wr_hi_en | input | 1 | Load strobe for the high counter |
| wr_hi_data | input | 8 | Load value for the high counter |
| cnt_lo | output | 8 | Low counter value |
| cnt_hi | output | 8 | High counter value |
| wrap_lo | output | 1 | One-cycle low wrap pulse |
| wrap_hi | output | 1 | One-cycle high wrap pulse |

## Verification
The assertions check on every cycle that a load beats an increment and that a stopped counter holds its value. They also check that the frozen high byte stays put in chained mode, that the high byte never moves in chained mode without a low-byte carry, and that each wrap pulse lines up with a real all-ones-to-zero step. Whether each counter advances by exactly the right amount under each mix of run pins and mode can only be shown by the bench. The same holds for the exact cycle in which a carry lands across the byte boundary, and for the absence of a high pulse on a partial wrap. The bench shows these through its scenario sequences against a cycle model.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic {
    CHAIN_OFF = 1'b0,
    CHAIN_ON  = 1'b1
  } chain_mode_e;

  localparam int unsigned NUM_UNITS = 2;
  localparam int unsigned IDX_LO    = 0;
  localparam int unsigned IDX_HI    = 1;
endpackage

// File: rtl/ctmr_byte_cnt.sv
module ctmr_byte_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] val_o,
  output logic         full_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] val_q;
  logic         wrap_q;

  assign full_o = (val_q == ALL_ONES);
  assign val_o  = val_q;
  assign wrap_o = wrap_q;

  // load wins over increment; wrap pulse registered with the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= inc_i && !ld_i && full_o;
      if (ld_i)       val_q <= ld_val_i;
      else if (inc_i) val_q <= val_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctmr_step_gate.sv
module ctmr_step_gate
  import ctmr_pkg::*;
(
  input  chain_mode_e mode_i,
  input  logic        tick_i,
  input  logic        run_lo_i,
  input  logic        run_hi_i,
  input  logic        ld_lo_i,
  input  logic        lo_full_i,
  output logic        inc_lo_o,
  output logic        inc_hi_o
);
  logic carry;

  always_comb begin
    inc_lo_o = tick_i && run_lo_i && !ld_lo_i;
    carry    = inc_lo_o && lo_full_i;
    unique case (mode_i)
      CHAIN_ON:  inc_hi_o = carry && run_hi_i;
      default:   inc_hi_o = tick_i && run_hi_i;
    endcase
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ctmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              join16,
  input  logic              run_lo,
  input  logic              run_hi,
  input  logic              wr_lo_en,
  input  logic [BYTE_W-1:0] wr_lo_data,
  input  logic              wr_hi_en,
  input  logic [BYTE_W-1:0] wr_hi_data,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              wrap_lo,
  output logic              wrap_hi
);
  logic [NUM_UNITS-1:0] inc_v;
  logic [NUM_UNITS-1:0] ld_v;
  logic [NUM_UNITS-1:0] full_v;
  logic [NUM_UNITS-1:0] wrap_v;
  logic [BYTE_W-1:0]    ld_val_a [NUM_UNITS];
  logic [BYTE_W-1:0]    val_a    [NUM_UNITS];
  logic                 inc_lo_w;
  logic                 inc_hi_w;

  assign ld_v[IDX_LO]     = wr_lo_en;
  assign ld_v[IDX_HI]     = wr_hi_en;
  assign ld_val_a[IDX_LO] = wr_lo_data;
  assign ld_val_a[IDX_HI] = wr_hi_data;
  assign inc_v[IDX_LO]    = inc_lo_w;
  assign inc_v[IDX_HI]    = inc_hi_w;

  ctmr_step_gate u_gate (
    .mode_i    (chain_mode_e'(join16)),
    .tick_i    (tick),
    .run_lo_i  (run_lo),
    .run_hi_i  (run_hi),
    .ld_lo_i   (wr_lo_en),
    .lo_full_i (full_v[IDX_LO]),
    .inc_lo_o  (inc_lo_w),
    .inc_hi_o  (inc_hi_w)
  );

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    ctmr_byte_cnt #(.W(BYTE_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (inc_v[g]),
      .ld_i     (ld_v[g]),
      .ld_val_i (ld_val_a[g]),
      .val_o    (val_a[g]),
      .full_o   (full_v[g]),
      .wrap_o   (wrap_v[g])
    );
  end

  assign cnt_lo  = val_a[IDX_LO];
  assign cnt_hi  = val_a[IDX_HI];
  assign wrap_lo = wrap_v[IDX_LO];
  assign wrap_hi = wrap_v[IDX_HI];
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              join16,
  input logic              run_lo,
  input logic              run_hi,
  input logic              wr_lo_en,
  input logic [BYTE_W-1:0] wr_lo_data,
  input logic              wr_hi_en,
  input logic [BYTE_W-1:0] wr_hi_data,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              wrap_lo,
  input logic              wrap_hi
);
  localparam logic [BYTE_W-1:0] ONES = '1;

  p_wr_lo_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_en |=> cnt_lo == $past(wr_lo_data));

  p_wr_hi_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_en |=> cnt_hi == $past(wr_hi_data));

  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo_en && (!tick || !run_lo)) |=> $stable(cnt_lo));

  p_hi_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (join16 && !run_hi && !wr_hi_en) |=> $stable(cnt_hi));

  p_hi_needs_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (join16 && !wr_hi_en && (cnt_lo != ONES || !tick || !run_lo || wr_lo_en))
      |=> $stable(cnt_hi));

  p_wrap_lo_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_lo |-> (cnt_lo == '0 && $past(cnt_lo) == ONES));

  p_wrap_lo_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_lo |=> !wrap_lo);

  p_wrap_hi_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hi |-> (cnt_hi == '0 && $past(cnt_hi) == ONES));

  p_wrap_hi_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_hi && $past(join16)) |-> (cnt_lo == '0 && wrap_lo));
endmodule

bind cascade_timer ctmr_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .join16     (join16),
  .run_lo     (run_lo),
  .run_hi     (run_hi),
  .wr_lo_en   (wr_lo_en),
  .wr_lo_data (wr_lo_data),
  .wr_hi_en   (wr_hi_en),
  .wr_hi_data (wr_hi_data),
  .cnt_lo     (cnt_lo),
  .cnt_hi     (cnt_hi),
  .wrap_lo    (wrap_lo),
  .wrap_hi    (wrap_hi)
);

// File: tb/cascade_timer_tb_top.sv
module cascade_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, join16 = 1'b0, run_lo = 1'b0, run_hi = 1'b0;
  logic       wr_lo_en = 1'b0, wr_hi_en = 1'b0;
  logic [7:0] wr_lo_data = '0, wr_hi_data = '0;
  logic [7:0] cnt_lo, cnt_hi;
  logic       wrap_lo, wrap_hi;

  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       wl;
    logic       wh;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] m_lo = '0, m_hi = '0;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .join16(join16),
    .run_lo(run_lo), .run_hi(run_hi),
    .wr_lo_en(wr_lo_en), .wr_lo_data(wr_lo_data),
    .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .wrap_lo(wrap_lo), .wrap_hi(wrap_hi)
  );

  task automatic compare(input exp_t e);
    n_vec++;
    if (cnt_lo !== e.lo || cnt_hi !== e.hi || wrap_lo !== e.wl || wrap_hi !== e.wh) begin
      n_bad++;
      $display("FAIL %s: lo=%02h hi=%02h wl=%0b wh=%0b expected lo=%02h hi=%02h wl=%0b wh=%0b",
               e.tag, cnt_lo, cnt_hi, wrap_lo, wrap_hi, e.lo, e.hi, e.wl, e.wh);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic t, input logic j, input logic rl, input logic rh,
                      input logic wle, input logic [7:0] wld,
                      input logic whe, input logic [7:0] whd, input string tag);
    exp_t e;
    logic inc_lo, carry, inc_hi;
    @(negedge clk);
    tick = t; join16 = j; run_lo = rl; run_hi = rh;
    wr_lo_en = wle; wr_lo_data = wld; wr_hi_en = whe; wr_hi_data = whd;
    inc_lo = t && rl && !wle;
    carry  = inc_lo && (m_lo == 8'hFF);
    inc_hi = !whe && t && rh && (j ? carry : 1'b1);
    e.wl = carry;
    e.wh = inc_hi && (m_hi == 8'hFF);
    if (wle) m_lo = wld; else if (inc_lo) m_lo = m_lo + 8'd1;
    if (whe) m_hi = whd; else if (inc_hi) m_hi = m_hi + 8'd1;
    e.lo = m_lo; e.hi = m_hi; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic ticks(input int n, input logic j, input logic rl, input logic rh, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, j, rl, rh, 1'b0, 8'h00, 1'b0, 8'h00, tag);
  endtask

  task automatic load(input logic j, input logic wle, input logic [7:0] lo,
                      input logic whe, input logic [7:0] hi, input string tag);
    step(1'b0, j, 1'b0, 1'b0, wle, lo, whe, hi, tag);
  endtask

  // monitor: pops expected items just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.lo = 8'h00; r.hi = 8'h00; r.wl = 1'b0; r.wh = 1'b0; r.tag = "R1 reset";
    compare(r);
    rst_n = 1'b1;

    // R2: independent counting
    ticks(3, 1'b0, 1'b1, 1'b0, "R2 low only");
    ticks(2, 1'b0, 1'b0, 1'b1, "R2 high only");
    // R3: tick low holds both
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R3 no tick");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R3 no tick");
    // R7: load beats increment
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h40, 1'b1, 8'h55, "R7 load vs tick");
    ticks(1, 1'b0, 1'b1, 1'b1, "R2 both run");
    // R8 / R9: wraps in split mode
    load(1'b0, 1'b1, 8'hFE, 1'b0, 8'h00, "R7 load lo");
    ticks(3, 1'b0, 1'b1, 1'b0, "R8 low wrap");
    load(1'b0, 1'b0, 8'h00, 1'b1, 8'hFF, "R7 load hi");
    ticks(2, 1'b0, 1'b0, 1'b1, "R9 high wrap split");
    // R4: chained carry lands on the low wrap, no high pulse (R10)
    load(1'b1, 1'b1, 8'hFD, 1'b1, 8'h12, "R7 load pair");
    ticks(4, 1'b1, 1'b1, 1'b1, "R4 chained carry / R10");
    // R6: low run off stops pair
    ticks(3, 1'b1, 1'b0, 1'b1, "R6 pair stopped");
    // R5: high byte frozen
    load(1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, "R7 load lo");
    ticks(2, 1'b1, 1'b1, 1'b0, "R5 upper frozen");
    // R10: full wrap
    load(1'b1, 1'b1, 8'hFF, 1'b1, 8'hFF, "R7 load pair");
    ticks(2, 1'b1, 1'b1, 1'b1, "R10 full wrap");
    // R7: low load in chained mode produces no carry
    load(1'b1, 1'b1, 8'hFF, 1'b1, 8'h20, "R7 load pair");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h05, 1'b0, 8'h00, "R7 no carry on load");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R3 idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule